// File: doc/BRIEF.md
# Fractional DSP Arithmetic Unit

This block is the execution stage of a 32-bit audio signal processor. Each clock it takes a 4-bit opcode and three signed operands, A, X and Y. One clock edge later it presents a result R and a five-bit condition-code vector. Operands use Q31 fractional format (0x40000000 is 0.5), except in the integer-multiply opcodes. The multiply-accumulate opcodes come in saturating and wrapping forms, and each form has a variant that negates the product. The unit also has an integer multiply-add, a three-input add, a mask/toggle logic operation, three compare-and-select operations and a linear interpolation.

A shadow accumulator sits beside the result path. One opcode passes A straight to R and adds the fractional product X·Y into this accumulator. The accumulator is visible on its own output. Two opcode slots are reserved for log/exponent conversion, and the conditional-skip slot is handled by a sequencer elsewhere. In this unit all three return A unchanged with every flag clear. Operand fetch and instruction decode happen upstream.

Top module: `dsp_alu`

## Requirements
- R1: In the fractional opcodes the product term is floor(P / 2^31), where P is the full signed 64-bit product of X and Y. The operations are: 0x0 gives A + floor(X·Y/2^31) saturated; 0x1 gives A + floor(−X·Y/2^31) saturated; 0x2 and 0x3 compute the same two sums but keep the low 32 bits (wraparound).
- R2: Opcode 0x4 gives A + X·Y (integer product) saturated to 32 bits. Opcode 0x5 gives the same sum wrapped to 31 bits: R[30:0] = sum[30:0] and R[31] = sum[30].
- R3: Opcode 0x6 gives A + X + Y saturated.
- R4: Saturation is computed from an intermediate wider than 64 bits. A sum above 0x7FFFFFFF clamps to 0x7FFFFFFF and a sum below −2^31 clamps to 0x80000000. Condition bit 4 (saturate) is set exactly when a saturating opcode (0x0, 0x1, 0x4, 0x6, 0xE) clamped its result, and is clear otherwise.
- R5: Opcode 0x7 gives R = A and adds floor(X·Y/2^31) into an accumulator ACC_W bits wide (default 40) that wraps modulo 2^ACC_W. Every other opcode leaves the accumulator unchanged.
- R6: Opcode 0x8 gives R = (A AND X) XOR Y.
- R7: The compare opcodes use a signed comparison of A against Y. Opcode 0x9 gives X if A ≥ Y and NOT X otherwise; 0xA gives X if A ≥ Y and Y otherwise; 0xB gives X if A < Y and Y otherwise. Condition bit 1 (borrow) is set when A < Y taken as unsigned numbers, and only on these three opcodes.
- R8: Opcode 0xE gives A + floor(X·(Y − A)/2^31), saturated. Y − A is formed at 33 bits, so it cannot overflow.
- R9: For every opcode except 0xC, 0xD and 0xF, the flags are taken from R: bit 2 (minus) = R[31], bit 3 (zero) = (R == 0), and bit 0 (normalized) = R[31] XOR R[30].
- R10: Opcodes 0xC, 0xD and 0xF give R = A with all five condition bits clear.
- R11: R, the condition bits and the accumulator are registered. They change only at a rising clock edge, one edge after their operands are presented. A synchronous active-high reset clears all three to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opc_i | input | 4 | Operation code |
| a_i | input | DATA_W | Operand A (signed) |
| x_i | input | DATA_W | Operand X (signed) |
| y_i | input | DATA_W | Operand Y (signed) |
| res_o | output | DATA_W | Registered result R |
| cc_o | output | 5 | Registered condition bits {saturate, zero, minus, borrow, normalized} |
| acc_o | output | ACC_W | Shadow accumulator |

## Verification
The bound checker watches several rules on every cycle:
- A raised saturate bit always comes with one of the two clamp values, and only after a saturating opcode.
- Borrow appears only after a compare opcode.
- The minus, zero and normalized bits always agree with the registered result.
- The pass-through opcodes return A with no flags.
- The accumulator stays stable whenever the opcode is not the accumulate-move.

The arithmetic itself can only be shown by the bench's scenarios. These include:
- the floor rounding of negative fractional products and the difference this makes between plain and negated products;
- the −1.0 × −1.0 edge case;
- 31-bit integer wrap;
- unsigned borrow against the signed selection;
- interpolation with a 33-bit difference;
- an accumulator running past 32 bits.

// File: rtl/dsp_alu_pkg.sv
`timescale 1ns/1ps
package dsp_alu_pkg;

  typedef enum logic [3:0] {
    OP_FMAC_S  = 4'h0,
    OP_FMSC_S  = 4'h1,
    OP_FMAC_W  = 4'h2,
    OP_FMSC_W  = 4'h3,
    OP_IMAC_S  = 4'h4,
    OP_IMAC_W  = 4'h5,
    OP_ADD3_S  = 4'h6,
    OP_ACC_MV  = 4'h7,
    OP_ANDXOR  = 4'h8,
    OP_TSTNEG  = 4'h9,
    OP_LIM_GE  = 4'hA,
    OP_LIM_LT  = 4'hB,
    OP_LOG_PS  = 4'hC,
    OP_EXP_PS  = 4'hD,
    OP_INTERP  = 4'hE,
    OP_SKIP_PS = 4'hF
  } opc_e;

  localparam int CC_W      = 5;
  localparam int CC_NORM   = 0;
  localparam int CC_BORROW = 1;
  localparam int CC_MINUS  = 2;
  localparam int CC_ZERO   = 3;
  localparam int CC_SAT    = 4;

  function automatic logic is_pass(opc_e op);
    return (op == OP_LOG_PS) || (op == OP_EXP_PS) || (op == OP_SKIP_PS);
  endfunction

  function automatic logic is_cmp(opc_e op);
    return (op == OP_TSTNEG) || (op == OP_LIM_GE) || (op == OP_LIM_LT);
  endfunction

  function automatic logic is_satop(opc_e op);
    return (op == OP_FMAC_S) || (op == OP_FMSC_S) || (op == OP_IMAC_S) ||
           (op == OP_ADD3_S) || (op == OP_INTERP);
  endfunction

endpackage

// File: rtl/dsp_alu_mult.sv
`timescale 1ns/1ps
// Both multipliers: X*Y for the MAC paths and X*(Y-A) for interpolation.
module dsp_alu_mult #(
  parameter int W = 32
) (
  input  logic signed [W-1:0]   a_i,
  input  logic signed [W-1:0]   x_i,
  input  logic signed [W-1:0]   y_i,
  output logic signed [2*W-1:0] pxy_o,
  output logic signed [2*W:0]   pint_o
);
  logic signed [W:0] diff;

  assign diff   = {y_i[W-1], y_i} - {a_i[W-1], a_i};
  assign pxy_o  = x_i * y_i;
  assign pint_o = x_i * diff;
endmodule

// File: rtl/dsp_alu_sat.sv
`timescale 1ns/1ps
// Clamp a wide signed sum into OUT_W bits and report whether it clamped.
module dsp_alu_sat #(
  parameter int IN_W  = 68,
  parameter int OUT_W = 32
) (
  input  logic signed [IN_W-1:0] d_i,
  output logic [OUT_W-1:0]       q_o,
  output logic                   clamp_o
);
  localparam logic signed [IN_W-1:0] MAX_EXT =
    {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] MIN_EXT =
    {{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  always_comb begin
    if (d_i > MAX_EXT) begin
      q_o     = {1'b0, {(OUT_W-1){1'b1}}};
      clamp_o = 1'b1;
    end else if (d_i < MIN_EXT) begin
      q_o     = {1'b1, {(OUT_W-1){1'b0}}};
      clamp_o = 1'b1;
    end else begin
      q_o     = d_i[OUT_W-1:0];
      clamp_o = 1'b0;
    end
  end
endmodule

// File: rtl/dsp_alu_cmp.sv
`timescale 1ns/1ps
// Logic and compare/select group, plus the unsigned borrow bit.
module dsp_alu_cmp
  import dsp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  opc_e         op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] r_o,
  output logic         borrow_o
);
  logic ge_s;
  logic lt_u;

  assign ge_s = $signed(a_i) >= $signed(y_i);
  assign lt_u = a_i < y_i;

  always_comb begin
    r_o      = a_i;
    borrow_o = 1'b0;
    case (op_i)
      OP_ANDXOR: r_o = (a_i & x_i) ^ y_i;
      OP_TSTNEG: begin r_o = ge_s ? x_i : ~x_i; borrow_o = lt_u; end
      OP_LIM_GE: begin r_o = ge_s ? x_i : y_i;  borrow_o = lt_u; end
      OP_LIM_LT: begin r_o = ge_s ? y_i : x_i;  borrow_o = lt_u; end
      default:   r_o = a_i;
    endcase
  end
endmodule

// File: rtl/dsp_alu.sv
`timescale 1ns/1ps
module dsp_alu
  import dsp_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        opc_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  output logic [DATA_W-1:0] res_o,
  output logic [CC_W-1:0]   cc_o,
  output logic [ACC_W-1:0]  acc_o
);
  localparam int SW  = 2*DATA_W + 4;  // headroom for every sum
  localparam int FSH = DATA_W - 1;    // Q31 product shift

  opc_e op;
  assign op = opc_e'(opc_i);

  logic signed [DATA_W-1:0]   a_s, x_s, y_s;
  logic signed [2*DATA_W-1:0] pxy;
  logic signed [2*DATA_W:0]   pint;
  logic signed [SW-1:0]       a_e, x_e, y_e, p_e, n_e, i_e;
  logic signed [SW-1:0]       frac_p, frac_n, frac_i, sum;

  assign a_s = a_i;
  assign x_s = x_i;
  assign y_s = y_i;

  dsp_alu_mult #(.W(DATA_W)) i_mult (
    .a_i(a_s), .x_i(x_s), .y_i(y_s), .pxy_o(pxy), .pint_o(pint)
  );

  assign a_e    = a_s;
  assign x_e    = x_s;
  assign y_e    = y_s;
  assign p_e    = pxy;
  assign n_e    = -p_e;
  assign i_e    = pint;
  assign frac_p = p_e >>> FSH;
  assign frac_n = n_e >>> FSH;
  assign frac_i = i_e >>> FSH;

  always_comb begin
    case (op)
      OP_FMAC_S, OP_FMAC_W: sum = a_e + frac_p;
      OP_FMSC_S, OP_FMSC_W: sum = a_e + frac_n;
      OP_IMAC_S, OP_IMAC_W: sum = a_e + p_e;
      OP_ADD3_S:            sum = a_e + x_e + y_e;
      OP_INTERP:            sum = a_e + frac_i;
      default:              sum = a_e;
    endcase
  end

  logic [DATA_W-1:0] sat_q;
  logic              sat_hit;

  dsp_alu_sat #(.IN_W(SW), .OUT_W(DATA_W)) i_sat (
    .d_i(sum), .q_o(sat_q), .clamp_o(sat_hit)
  );

  logic [DATA_W-1:0] cmp_r;
  logic              cmp_borrow;

  dsp_alu_cmp #(.W(DATA_W)) i_cmp (
    .op_i(op), .a_i(a_i), .x_i(x_i), .y_i(y_i),
    .r_o(cmp_r), .borrow_o(cmp_borrow)
  );

  logic [DATA_W-1:0] r_nxt;
  logic [CC_W-1:0]   cc_nxt;

  always_comb begin
    if (is_satop(op))
      r_nxt = sat_q;
    else if (op == OP_FMAC_W || op == OP_FMSC_W)
      r_nxt = sum[DATA_W-1:0];
    else if (op == OP_IMAC_W)
      r_nxt = {sum[DATA_W-2], sum[DATA_W-2:0]};
    else if (is_cmp(op) || op == OP_ANDXOR)
      r_nxt = cmp_r;
    else
      r_nxt = a_i;
  end

  always_comb begin
    cc_nxt = '0;
    if (!is_pass(op)) begin
      cc_nxt[CC_NORM]   = r_nxt[DATA_W-1] ^ r_nxt[DATA_W-2];
      cc_nxt[CC_BORROW] = cmp_borrow;
      cc_nxt[CC_MINUS]  = r_nxt[DATA_W-1];
      cc_nxt[CC_ZERO]   = (r_nxt == '0);
      cc_nxt[CC_SAT]    = is_satop(op) & sat_hit;
    end
  end

  logic [DATA_W-1:0] res_q;
  logic [CC_W-1:0]   cc_q;
  logic [ACC_W-1:0]  acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      cc_q  <= '0;
      acc_q <= '0;
    end else begin
      res_q <= r_nxt;
      cc_q  <= cc_nxt;
      if (op == OP_ACC_MV)
        acc_q <= acc_q + frac_p[ACC_W-1:0];
    end
  end

  assign res_o = res_q;
  assign cc_o  = cc_q;
  assign acc_o = acc_q;
endmodule

// File: rtl/dsp_alu_chk.sv
`timescale 1ns/1ps
module dsp_alu_chk
  import dsp_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 40
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        opc_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] res_o,
  input logic [CC_W-1:0]   cc_o,
  input logic [ACC_W-1:0]  acc_o
);
  localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_MAX = {1'b1, {(DATA_W-1){1'b0}}};

  logic live, prev_pass, prev_cmp, prev_sat;

  always_ff @(posedge clk) begin
    if (rst) begin
      live      <= 1'b0;
      prev_pass <= 1'b0;
      prev_cmp  <= 1'b0;
      prev_sat  <= 1'b0;
    end else begin
      live      <= 1'b1;
      prev_pass <= is_pass(opc_e'(opc_i));
      prev_cmp  <= is_cmp(opc_e'(opc_i));
      prev_sat  <= is_satop(opc_e'(opc_i));
    end
  end

  AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (rst)
    cc_o[CC_SAT] |-> (res_o == POS_MAX || res_o == NEG_MAX));  // R4
  AST_SAT_ONLY_SATOPS: assert property (@(posedge clk) disable iff (rst)
    (live && cc_o[CC_SAT]) |-> prev_sat);  // R4
  AST_BORROW_ONLY_CMP: assert property (@(posedge clk) disable iff (rst)
    (live && cc_o[CC_BORROW]) |-> prev_cmp);  // R7
  AST_FLAGS_TRACK_RES: assert property (@(posedge clk) disable iff (rst)
    (live && !prev_pass) |-> (cc_o[CC_MINUS] == res_o[DATA_W-1] &&
                              cc_o[CC_ZERO] == (res_o == '0) &&
                              cc_o[CC_NORM] == (res_o[DATA_W-1] ^ res_o[DATA_W-2])));  // R9
  AST_PASS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (live && prev_pass) |-> (cc_o == '0));  // R10
  AST_PASS_RETURNS_A: assert property (@(posedge clk) disable iff (rst)
    is_pass(opc_e'(opc_i)) |=> (res_o == $past(a_i)));  // R10
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (opc_i != OP_ACC_MV) |=> $stable(acc_o));  // R5
  AST_ACC_MV_PASS: assert property (@(posedge clk) disable iff (rst)
    (opc_i == OP_ACC_MV) |=> (res_o == $past(a_i)));  // R5
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (res_o == '0 && cc_o == '0 && acc_o == '0));  // R11
endmodule

bind dsp_alu dsp_alu_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) i_chk (
  .clk(clk), .rst(rst), .opc_i(opc_i), .a_i(a_i),
  .res_o(res_o), .cc_o(cc_o), .acc_o(acc_o)
);

// File: tb/test_dsp_alu.sv
`timescale 1ns/1ps
module test_dsp_alu;
  localparam int DW = 32;
  localparam int AW = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    opc = 4'h8;
  logic [DW-1:0] a = '0, x = '0, y = '0;
  logic [DW-1:0] res;
  logic [4:0]    cc;
  logic [AW-1:0] acc;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dsp_alu #(.DATA_W(DW), .ACC_W(AW)) i_dsp_alu (
    .clk(clk), .rst(rst), .opc_i(opc), .a_i(a), .x_i(x), .y_i(y),
    .res_o(res), .cc_o(cc), .acc_o(acc)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a, x, y, r;
    logic [4:0]  cc;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  // cc = {sat, zero, minus, borrow, norm}
  localparam vec_t TBL [NV] = '{
    '{4'h0, 32'h00000010, 32'h40000000, 32'h40000000, 32'h20000010, 5'h00, 4'd1},  // R1
    '{4'h0, 32'h7FFFFFFF, 32'h40000000, 32'h40000000, 32'h7FFFFFFF, 5'h11, 4'd4},  // R4
    '{4'h2, 32'h7FFFFFFF, 32'h40000000, 32'h40000000, 32'h9FFFFFFF, 5'h05, 4'd1},  // R1
    '{4'h1, 32'h00000000, 32'h40000000, 32'h40000000, 32'hE0000000, 5'h04, 4'd1},  // R1
    '{4'h3, 32'h80000000, 32'h40000000, 32'h40000000, 32'h60000000, 5'h01, 4'd1},  // R1
    '{4'h1, 32'h80000000, 32'h40000000, 32'h40000000, 32'h80000000, 5'h15, 4'd4},  // R4
    '{4'h0, 32'h00000000, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF, 5'h04, 4'd1},  // R1 floor
    '{4'h1, 32'h00000000, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 5'h08, 4'd1},  // R1 floor
    '{4'h4, 32'h00000005, 32'h00000003, 32'hFFFFFFFE, 32'hFFFFFFFF, 5'h04, 4'd2},  // R2
    '{4'h4, 32'h00000000, 32'h00010000, 32'h00010000, 32'h7FFFFFFF, 5'h11, 4'd2},  // R2
    '{4'h5, 32'h00000000, 32'h00010000, 32'h00008000, 32'h00000000, 5'h08, 4'd2},  // R2
    '{4'h5, 32'h00000000, 32'h00008000, 32'h00008000, 32'hC0000000, 5'h04, 4'd2},  // R2
    '{4'h6, 32'h00000001, 32'h00000002, 32'h00000003, 32'h00000006, 5'h00, 4'd3},  // R3
    '{4'h6, 32'h7FFFFFFF, 32'h00000001, 32'h00000000, 32'h7FFFFFFF, 5'h11, 4'd3},  // R3
    '{4'h6, 32'h80000000, 32'hFFFFFFFF, 32'h00000000, 32'h80000000, 5'h15, 4'd3},  // R3
    '{4'h8, 32'hFF00FF00, 32'h0F0F0F0F, 32'h000000FF, 32'h0F000FFF, 5'h00, 4'd6},  // R6
    '{4'h9, 32'h00000005, 32'h12345678, 32'h00000003, 32'h12345678, 5'h00, 4'd7},  // R7
    '{4'h9, 32'hFFFFFFFF, 32'h12345678, 32'h00000001, 32'hEDCBA987, 5'h04, 4'd7},  // R7
    '{4'hA, 32'h00000002, 32'h00000100, 32'h00000007, 32'h00000007, 5'h02, 4'd7},  // R7
    '{4'hA, 32'h00000009, 32'h00000100, 32'h00000007, 32'h00000100, 5'h00, 4'd7},  // R7
    '{4'hA, 32'h00000001, 32'h00000100, 32'hFFFFFFFF, 32'h00000100, 5'h02, 4'd7},  // R7
    '{4'hB, 32'h00000002, 32'h00000100, 32'h00000007, 32'h00000100, 5'h02, 4'd7},  // R7
    '{4'hB, 32'h00000007, 32'h00000100, 32'h00000007, 32'h00000007, 5'h00, 4'd7},  // R7
    '{4'hE, 32'h00000000, 32'h40000000, 32'h40000000, 32'h20000000, 5'h00, 4'd8},  // R8
    '{4'hE, 32'h40000000, 32'h40000000, 32'h00000000, 32'h20000000, 5'h00, 4'd8},  // R8
    '{4'hE, 32'h7FFFFFFF, 32'h80000000, 32'h80000000, 32'h7FFFFFFF, 5'h11, 4'd8},  // R8
    '{4'hC, 32'h80000000, 32'h00001234, 32'h00005678, 32'h80000000, 5'h00, 4'd10}, // R10
    '{4'hD, 32'h00000000, 32'h00000001, 32'h00000001, 32'h00000000, 5'h00, 4'd10}, // R10
    '{4'hF, 32'h00000055, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000055, 5'h00, 4'd10}, // R10
    '{4'h7, 32'h00000033, 32'h00000000, 32'h00000000, 32'h00000033, 5'h00, 4'd5}   // R5
  };

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Present one operation for exactly one rising edge, then sample after it.
  task automatic issue(input logic [3:0] op, input logic [31:0] va,
                       input logic [31:0] vx, input logic [31:0] vy);
    @(negedge clk);
    opc = op; a = va; x = vx; y = vy;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset res", 64'(res), 64'h0);
    check("R11 reset cc", 64'(cc), 64'h0);
    check("R11 reset acc", 64'(acc), 64'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(TBL[i].op, TBL[i].a, TBL[i].x, TBL[i].y);
      check($sformatf("R%0d vec%0d res", TBL[i].req, i), 64'(res), 64'(TBL[i].r));
      check($sformatf("R%0d vec%0d cc", TBL[i].req, i), 64'(cc), 64'(TBL[i].cc));
    end

    // R5: accumulator walk, growing beyond 32 bits
    issue(4'h7, 32'h1, 32'h40000000, 32'h40000000);
    check("R5 acc +0.25", 64'(acc), 64'h20000000);
    issue(4'h7, 32'h1, 32'h40000000, 32'h40000000);
    check("R5 acc +0.25 again", 64'(acc), 64'h40000000);
    issue(4'h7, 32'h2, 32'hFFFFFFFF, 32'h00000001);
    check("R5 acc floor -1", 64'(acc), 64'h3FFFFFFF);
    check("R5 res is A", 64'(res), 64'h2);
    issue(4'h8, 32'h0, 32'h40000000, 32'h40000000);
    check("R5 acc ignores andxor", 64'(acc), 64'h3FFFFFFF);
    issue(4'h0, 32'h0, 32'h80000000, 32'h80000000);
    check("R5 acc ignores mac", 64'(acc), 64'h3FFFFFFF);
    check("R4 min*min saturates", 64'(res), 64'h7FFFFFFF);
    issue(4'h2, 32'h0, 32'h80000000, 32'h80000000);
    check("R1 min*min wraps", 64'(res), 64'h80000000);
    issue(4'h7, 32'h0, 32'h80000000, 32'h80000000);
    check("R5 acc past 32 bits", 64'(acc), 64'hBFFFFFFF);
    issue(4'h7, 32'h0, 32'h80000000, 32'h7FFFFFFF);
    check("R5 acc negative add", 64'(acc), 64'h40000000);

    // R11: nothing moves before the edge
    @(negedge clk);
    opc = 4'h6; a = 32'h10; x = 32'h20; y = 32'h30;
    #1;
    check("R11 res held before edge", 64'(res), 64'h0);
    @(posedge clk);
    #1;
    check("R11 res after edge", 64'(res), 64'h60);

    // R11: reset mid-run clears the accumulator
    @(negedge clk);
    opc = 4'h8;
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R11 mid reset acc", 64'(acc), 64'h0);
    check("R11 mid reset res", 64'(res), 64'h0);
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
    finish_run();
  end
endmodule